// File: doc/BRIEF.md
# Isolated Open-Drain Bus Repeater with Pulse Stretching

This block models, at clock-cycle level, a repeater that joins two open-drain buses through an isolating channel. The channel has latency in each direction. Side A carries the bus master. It has a bidirectional data line and a clock input. Side B has a bidirectional data line and a clock output only, so clock information flows from A to B and never back. Each line appears as an input sample plus a pull-low enable. The two channel directions are fixed-length delay lines. All inputs are resynchronized before use.

The side-B data input is the level seen through a lowered threshold. That threshold lies below side B's own driven low, so the sample reflects only external drivers. The input is glitch-filtered. When a low is accepted, a hold latch pulls side B low and keeps the request to side A asserted until side A's low comes back over the channel. A short side-B pulse therefore becomes one stretched pulse on each side, and both lines return high afterwards.

A controller on side B has four states:

| State | Meaning |
|---|---|
| ST_IDLE | No activity on the data line. |
| ST_HOLD | The latch is set after side B accepted a low. |
| ST_ECHO | The latch is cleared and side A's returned low holds side B. |
| ST_FOLLOW | A low that started on side A is being repeated on side B. |

It has five transitions:

| Transition | From | To | Condition |
|---|---|---|---|
| accept | ST_IDLE | ST_HOLD | A filtered external low is present. Accept takes priority over follow. |
| follow | ST_IDLE | ST_FOLLOW | The side-A line state arrives low. |
| echo_back | ST_HOLD | ST_ECHO | The returned side-A state is low. |
| a_release from echo | ST_ECHO | ST_IDLE | The returned side-A state is high. |
| a_release from follow | ST_FOLLOW | ST_IDLE | The returned side-A state is high. |

Top module: `iso_od_repeater`

## Requirements

Notation used below:
- SY is the synchronizer depth.
- F is the filter length.
- DAB is the A-to-B channel delay in cycles.
- DBA is the B-to-A channel delay in cycles.
- Cycle n means the value just after the n-th rising edge that follows an input change.
- A pull enable is 1 when that line is driven low.
- An input sample is 1 when the line is high.

Requirements:
- R1: While reset is held, and directly after reset is released, all three pull enables are 0. The channel delay lines hold the idle-high value.
- R2: A side-B external low shorter than F cycles causes no pull on either side. A side-B external low of at least F cycles starts the side-A pull at cycle SY+F+DBA.
- R3: An accepted side-B low moves the controller to ST_HOLD. Side B's pull starts at cycle SY+F+1. Side B stays in ST_HOLD, pulling low and requesting side A, until the returned side-A state is low.
- R4: For an accepted side-B low of W cycles, the side-A pull lasts max(W, SY+1+DBA+DAB) cycles. A short pulse is therefore stretched to the round-trip time.
- R5: The side-B pull ends SY+DAB cycles after the side-A pull ends.
- R6: Every accepted side-B pulse gives exactly one falling edge of each of the two data pull enables. Afterwards both are 0. Side B's own drive never keeps it low: in ST_ECHO, a returned high leads to ST_IDLE.
- R7: A low of W cycles on the side-A data line pulls side B low from cycle SY+DAB for exactly W cycles. It never raises the side-A pull.
- R8: A low of W cycles on the side-A clock input pulls the side-B clock low from cycle SY+DAB for exactly W cycles. The clock path has no input on side B.
- R9: A side-B pulse longer than the round trip is not stretched. The side-A pull width equals W.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| a_sda_in | input | 1 | Side-A data line sample, including this block's own drive |
| a_scl_in | input | 1 | Side-A clock line sample from the master |
| b_sda_in | input | 1 | Side-B data line sample of external drivers only, taken through the lowered threshold |
| a_sda_pull | output | 1 | Pull side-A data line low |
| b_sda_pull | output | 1 | Pull side-B data line low |
| b_scl_pull | output | 1 | Pull side-B clock line low |

## Verification

Each result has a fixed due cycle, counted from the rising edge that first samples the stimulus:
- The side-A pull starts SY+F+DBA cycles after a side-B low begins.
- The side-B hold starts SY+F+1 cycles after that low begins.
- The side-B release comes SY+DAB cycles after side A releases.
- Side-A data and clock lows appear on side B after SY+DAB cycles.

The bench sweeps pulse widths on every input across the filter threshold and the round-trip length. It samples every cycle on the falling edge. For each pulse it records the first cycle of each pull, the pull width and the number of falling edges. It compares these with the expected values computed from the formulas above, using the parameters.

// File: rtl/rep_pkg.sv
package rep_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HOLD   = 2'd1,
        ST_ECHO   = 2'd2,
        ST_FOLLOW = 2'd3
    } b_state_t;
endpackage

// File: rtl/rep_delay_line.sv
// Fixed-length shift line, reset to the idle-high level. Used both as
// input synchronizer and as channel latency model.
module rep_delay_line #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [DEPTH-1:0] stage;

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage[0] <= 1'b1;
                else        stage[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage[i] <= 1'b1;
                else        stage[i] <= stage[i-1];
            end
        end
    end

    assign dout = stage[DEPTH-1];
endmodule

// File: rtl/rep_glitch_filter.sv
// Output follows input only after FILT_LEN consecutive differing samples.
module rep_glitch_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    logic [CW-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= 1'b1;
            run  <= '0;
        end else if (din == dout) begin
            run <= '0;
        end else if (run == LAST) begin
            dout <= din;
            run  <= '0;
        end else begin
            run <= run + 1'b1;
        end
    end
endmodule

// File: rtl/rep_b_ctrl.sv
// Side-B controller: hold latch, echo wait and follow of side-A lows.
module rep_b_ctrl
    import rep_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     acc_low,   // filtered external low on side B
    input  logic     ab_low,    // side-A line state returned low
    output b_state_t state,
    output logic     b_pull,
    output logic     send_low
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (acc_low)     state <= ST_HOLD;    // accept
                    else if (ab_low) state <= ST_FOLLOW;  // follow
                end
                ST_HOLD:   if (ab_low)  state <= ST_ECHO; // echo_back
                ST_ECHO:   if (!ab_low) state <= ST_IDLE; // a_release
                ST_FOLLOW: if (!ab_low) state <= ST_IDLE; // a_release
                default:   state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        b_pull   = (state == ST_HOLD) || ab_low;
        send_low = (state == ST_HOLD) || acc_low;
    end
endmodule

// File: rtl/iso_od_repeater.sv
module iso_od_repeater
    import rep_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3,
    parameter int DLY_AB      = 4,
    parameter int DLY_BA      = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic a_sda_in,
    input  logic a_scl_in,
    input  logic b_sda_in,
    output logic a_sda_pull,
    output logic b_sda_pull,
    output logic b_scl_pull
);
    logic a_sda_s, a_scl_s, b_sda_s, b_flt;
    logic ab_data, ab_scl, ba_data;
    logic acc_low, ab_low, send_low;
    b_state_t b_state;

    rep_delay_line #(.DEPTH(SYNC_STAGES)) u_sync_asda (
        .clk(clk), .rst_n(rst_n), .din(a_sda_in), .dout(a_sda_s));
    rep_delay_line #(.DEPTH(SYNC_STAGES)) u_sync_ascl (
        .clk(clk), .rst_n(rst_n), .din(a_scl_in), .dout(a_scl_s));
    rep_delay_line #(.DEPTH(SYNC_STAGES)) u_sync_bsda (
        .clk(clk), .rst_n(rst_n), .din(b_sda_in), .dout(b_sda_s));

    rep_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt_b (
        .clk(clk), .rst_n(rst_n), .din(b_sda_s), .dout(b_flt));

    rep_delay_line #(.DEPTH(DLY_AB)) u_chan_ab_sda (
        .clk(clk), .rst_n(rst_n), .din(a_sda_s), .dout(ab_data));
    rep_delay_line #(.DEPTH(DLY_AB)) u_chan_ab_scl (
        .clk(clk), .rst_n(rst_n), .din(a_scl_s), .dout(ab_scl));
    rep_delay_line #(.DEPTH(DLY_BA)) u_chan_ba_sda (
        .clk(clk), .rst_n(rst_n), .din(~send_low), .dout(ba_data));

    assign acc_low = ~b_flt;
    assign ab_low  = ~ab_data;

    rep_b_ctrl u_bctl (
        .clk(clk), .rst_n(rst_n), .acc_low(acc_low), .ab_low(ab_low),
        .state(b_state), .b_pull(b_sda_pull), .send_low(send_low));

    assign a_sda_pull = ~ba_data;
    assign b_scl_pull = ~ab_scl;
endmodule

// File: rtl/rep_checker.sv
module rep_checker
    import rep_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input b_state_t state,
    input logic     acc_low,
    input logic     ab_low,
    input logic     send_low,
    input logic     a_sda_pull,
    input logic     b_sda_pull,
    input logic     b_scl_pull
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n)) |-> (!a_sda_pull && !b_sda_pull && !b_scl_pull));

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && acc_low) |=> (state == ST_HOLD));

    // R3
    hold_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> (b_sda_pull && send_low));

    // R3
    hold_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !ab_low) |=> (state == ST_HOLD));

    // R6
    echo_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ECHO && !ab_low) |=> (state == ST_IDLE));
endmodule

bind iso_od_repeater rep_checker u_rep_chk (
    .clk(clk), .rst_n(rst_n), .state(b_state), .acc_low(acc_low),
    .ab_low(ab_low), .send_low(send_low), .a_sda_pull(a_sda_pull),
    .b_sda_pull(b_sda_pull), .b_scl_pull(b_scl_pull));

// File: tb/test_iso_od_repeater.sv
module test_iso_od_repeater;
    localparam int SY  = 2;
    localparam int F   = 3;
    localparam int DAB = 4;
    localparam int DBA = 4;
    localparam int OBS = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_ext_low = 1'b0, b_ext_low = 1'b0, scl_low = 1'b0;
    logic a_sda_pull, b_sda_pull, b_scl_pull;
    logic a_sda_in, b_sda_in, a_scl_in;
    int total = 0, bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    assign a_sda_in = ~(a_ext_low | a_sda_pull);
    assign b_sda_in = ~b_ext_low;
    assign a_scl_in = ~scl_low;

    iso_od_repeater #(.SYNC_STAGES(SY), .FILT_LEN(F), .DLY_AB(DAB), .DLY_BA(DBA))
    i_iso_od_repeater (
        .clk(clk), .rst_n(rst_n), .a_sda_in(a_sda_in), .a_scl_in(a_scl_in),
        .b_sda_in(b_sda_in), .a_sda_pull(a_sda_pull), .b_sda_pull(b_sda_pull),
        .b_scl_pull(b_scl_pull));

    task automatic check(input string req, input int w, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s w=%0d actual=%0d expected=%0d", req, w, act, exp);
        end
    endtask

    // kind 0: side-B data, 1: side-A data, 2: side-A clock
    task automatic pulse(input int kind, input int w);
        int af = -1, ac = 0, ae = 0, bf = -1, bc = 0, be = 0;
        logic pa = 1'b0, pb = 1'b0, pav, pbv;
        int loop_w, rel_a;
        @(negedge clk);
        if (kind == 0) b_ext_low = 1'b1;
        else if (kind == 1) a_ext_low = 1'b1;
        else scl_low = 1'b1;
        for (int n = 1; n <= OBS; n++) begin
            @(negedge clk);
            pav = a_sda_pull;
            pbv = (kind == 2) ? b_scl_pull : b_sda_pull;
            if (pav) begin if (af < 0) af = n; ac++; end
            if (pbv) begin if (bf < 0) bf = n; bc++; end
            if (pav && !pa) ae++;
            if (pbv && !pb) be++;
            pa = pav; pb = pbv;
            if (n >= w) begin b_ext_low = 1'b0; a_ext_low = 1'b0; scl_low = 1'b0; end
        end
        if (kind == 0) begin
            if (w < F) begin
                check("R2 short pulse a pull", w, ac, 0);
                check("R2 short pulse b pull", w, bc, 0);
            end else begin
                loop_w = SY + 1 + DBA + DAB;
                check("R2 a start", w, af, SY + F + DBA);
                check("R3 b hold start", w, bf, SY + F + 1);
                if (w > loop_w) check("R9 long pulse width", w, ac, w);
                else check("R4 stretched width", w, ac, loop_w);
                rel_a = af + ac;
                check("R5 b release", w, bf + bc, rel_a + SY + DAB);
                check("R6 one a edge", w, ae, 1);
                check("R6 one b edge", w, be, 1);
            end
            check("R6 released", w, int'(a_sda_pull | b_sda_pull), 0);
        end else begin
            check(kind == 1 ? "R7 b start" : "R8 b start", w, bf, SY + DAB);
            check(kind == 1 ? "R7 b width" : "R8 b width", w, bc, w);
            check(kind == 1 ? "R7 no a drive" : "R8 no a drive", w, ac, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset a", 0, int'(a_sda_pull), 0);
        check("R1 reset b", 0, int'(b_sda_pull), 0);
        check("R1 reset scl", 0, int'(b_scl_pull), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 0, int'(a_sda_pull | b_sda_pull | b_scl_pull), 0);
        for (int w = 1; w <= 24; w++) pulse(0, w);
        for (int w = 1; w <= 10; w++) pulse(1, w);
        for (int w = 1; w <= 10; w++) pulse(2, w);
        finished = 1;
    end

    initial begin
        fork
            wait (finished);
            repeat (200000) @(posedge clk);
        join_any
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule